// File: doc/BRIEF.md
# Bit-Serial Elastic Store for Clock Smoothing

This block is a single-bit elastic store placed between a jittery write side and a smoothed read side. Both sides run in one master clock domain. The write side supplies a bit together with a strobe derived from the recovered clock. The read side pulls bits on a strobe from the companion phase-locked loop. The store holds up to 48 bits. It reports how many bits it holds, and it remembers overflow and underrun events in sticky status bits. The interrupt output is the status bits gated by their own enables.

The loop controller can be told when the store is within one bit of either end. It then adjusts the output clock so that the store does not hit full or empty. A centering command jumps the read position to half depth in a single cycle. A bypass mode forwards the incoming bit and strobe straight to the output and freezes the store.

Top module: `jat_elastic_store`

## Requirements
- R1: The store holds up to 48 bits and returns them in write order. `fill` counts from 0 to 48 with no wrap. A write is taken when `fill` is below 48 and a read is taken when `fill` is above 0. The effect of an edge shows on the outputs after that edge.
- R2: A write while `fill` is 48 is an overflow. The bit is dropped, `fill` does not rise, and `ovr_flag` sets and stays set.
- R3: A read while `fill` is 0 is an underrun. `rd_bit` repeats the last bit read, the read position does not move, and `und_flag` sets and stays set.
- R4: A write and a read on the same edge leave `fill` unchanged when the store is neither full nor empty. When full, the read is taken and the write overflows. When empty, the write is taken and the read underruns.
- R5: `irq` is high exactly when (`ovr_flag` and `ovr_ie`) or (`und_flag` and `und_ie`) holds. The enables act at once, with no cycle of delay.
- R6: A one-cycle pulse on `clr_ovr` or `clr_und` clears the matching flag at the next edge. If a new event arrives on the same edge as the clear, the flag stays set.
- R7: With `lim_en` high, `near_full` is high when `fill` is 47 or more and `near_empty` is high when `fill` is 1 or less. With `lim_en` low, both are low.
- R8: `center_req`, when not in bypass, sets `fill` to 24 in one edge. It places the read position 24 bits behind the write position. Any read or write on that edge is ignored and raises no flag.
- R9: With `bypass` high, `rd_bit` follows `wr_bit` and `rd_valid` follows `wr_en` combinationally. Reads, writes and centering do not touch the store, and `fill` is kept.
- R10: Synchronous reset empties the store, clears both flags and `rd_bit`, and clears all storage cells to 0.
- R11: Outside bypass, `rd_valid` is high for the one cycle after each edge on which `rd_en` was high without centering. This covers both a taken read and an underrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the recovered clock |
| wr_bit | input | 1 | Data bit to store |
| rd_en | input | 1 | Read strobe from the smoothed clock |
| lim_en | input | 1 | Enables the near-full / near-empty outputs |
| center_req | input | 1 | Recenter the read position to half depth |
| bypass | input | 1 | Forward input straight to output, freeze store |
| ovr_ie | input | 1 | Interrupt enable for overflow |
| und_ie | input | 1 | Interrupt enable for underrun |
| clr_ovr | input | 1 | Clear pulse for the overflow flag |
| clr_und | input | 1 | Clear pulse for the underrun flag |
| rd_bit | output | 1 | Output data bit |
| rd_valid | output | 1 | Output strobe |
| fill | output | 6 | Number of bits held |
| ovr_flag | output | 1 | Sticky overflow status |
| und_flag | output | 1 | Sticky underrun status |
| irq | output | 1 | Masked interrupt |
| near_full | output | 1 | Store within one bit of full |
| near_empty | output | 1 | Store within one bit of empty |

## Verification
A pure fill to 48 followed by a pure drain checks ordering and the wrap of the positions across the whole depth. Extra writes at full and extra reads at empty separate a dropped bit from a stored one, and a repeated bit from a fresh one. Sustained paired reads and writes in mid range show that the count holds steady. Centering and bypass are each driven together with conflicting strobes, which shows the strobes are ignored on those edges. A long random mix then walks the fill level into both ends while flag clears, enable changes and mode changes are interleaved. A behavioural model compares every output on every cycle.

// File: rtl/jat_pkg.sv
package jat_pkg;

    localparam int unsigned JAT_DEFAULT_DEPTH = 48;

    // status flag slots
    localparam int unsigned FLG_OVR   = 0;
    localparam int unsigned FLG_UND   = 1;
    localparam int unsigned FLG_COUNT = 2;

    // per-edge operation decoded from the strobes and the fill level
    typedef struct packed {
        logic center;
        logic wr_go;
        logic rd_go;
        logic ovr_evt;
        logic und_evt;
    } jat_op_t;

    function automatic int unsigned jat_wrap_inc(int unsigned p, int unsigned depth);
        return (p + 1 == depth) ? 0 : p + 1;
    endfunction

    function automatic int unsigned jat_wrap_sub(int unsigned p, int unsigned off,
                                                 int unsigned depth);
        return (p >= off) ? p - off : p + depth - off;
    endfunction

endpackage

// File: rtl/jat_ptr_ctrl.sv
module jat_ptr_ctrl
    import jat_pkg::*;
#(
    parameter int unsigned DEPTH = JAT_DEFAULT_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             center_req,
    input  logic             bypass,
    output jat_op_t          op,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic [CNT_W-1:0] cnt
);

    localparam int unsigned      HALF     = DEPTH / 2;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF);
    localparam int unsigned      PAD_W    = 32 - PTR_W;

    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active, is_full, is_empty, plain;

    always_comb begin
        active    = !bypass;
        is_full   = (cnt_q == CNT_FULL);
        is_empty  = (cnt_q == '0);
        plain     = active && !center_req;
        op.center  = active && center_req;
        op.wr_go   = plain && wr_en && !is_full;
        op.rd_go   = plain && rd_en && !is_empty;
        op.ovr_evt = plain && wr_en && is_full;
        op.und_evt = plain && rd_en && is_empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else if (op.center) begin
            rptr_q <= PTR_W'(jat_wrap_sub({{PAD_W{1'b0}}, wptr_q}, HALF, DEPTH));
            cnt_q  <= CNT_HALF;
        end else begin
            if (op.wr_go)
                wptr_q <= PTR_W'(jat_wrap_inc({{PAD_W{1'b0}}, wptr_q}, DEPTH));
            if (op.rd_go)
                rptr_q <= PTR_W'(jat_wrap_inc({{PAD_W{1'b0}}, rptr_q}, DEPTH));
            case ({op.wr_go, op.rd_go})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign wptr = wptr_q;
    assign rptr = rptr_q;
    assign cnt  = cnt_q;

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_FULL); // R1

    AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op.und_evt && !wr_en) |=> (cnt_q == '0 && $stable(rptr_q))); // R3

    AST_PAIRED_STEADY: assert property (@(posedge clk) disable iff (rst)
        (plain && wr_en && rd_en && !is_full && !is_empty) |=> $stable(cnt_q)); // R4

    AST_CENTER_HALF: assert property (@(posedge clk) disable iff (rst)
        (center_req && !bypass) |=> (cnt_q == CNT_HALF)); // R8

    AST_BYPASS_FREEZE: assert property (@(posedge clk) disable iff (rst)
        bypass |=> ($stable(cnt_q) && $stable(wptr_q) && $stable(rptr_q))); // R9

endmodule

// File: rtl/jat_bit_store.sv
module jat_bit_store
    import jat_pkg::*;
#(
    parameter int unsigned DEPTH = JAT_DEFAULT_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_go,
    input  logic             wr_bit,
    input  logic [PTR_W-1:0] wptr,
    input  logic             rd_go,
    input  logic             und_evt,
    input  logic [PTR_W-1:0] rptr,
    output logic             out_bit,
    output logic             out_stb
);

    logic [DEPTH-1:0] cells;
    logic             out_bit_q, out_stb_q;

    // one flop per cell, written only when its address is selected
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[i] <= 1'b0;
            else if (wr_go && (wptr == PTR_W'(i)))
                cells[i] <= wr_bit;
        end
    end

    // an underrun leaves the output register alone, so the last bit repeats
    always_ff @(posedge clk) begin
        if (rst) begin
            out_bit_q <= 1'b0;
            out_stb_q <= 1'b0;
        end else begin
            if (rd_go)
                out_bit_q <= cells[rptr];
            out_stb_q <= rd_go || und_evt;
        end
    end

    assign out_bit = out_bit_q;
    assign out_stb = out_stb_q;

    AST_READ_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        rd_go |-> ({1'b0, rptr} < (PTR_W + 1)'(DEPTH))); // R1

    AST_UNDERRUN_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (und_evt && !rd_go) |=> $stable(out_bit_q)); // R3

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (rd_go || und_evt) |=> out_stb_q); // R11

endmodule

// File: rtl/jat_status.sv
module jat_status
    import jat_pkg::*;
#(
    parameter int unsigned NFLAG = FLG_COUNT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] evt,
    input  logic [NFLAG-1:0] clr,
    input  logic [NFLAG-1:0] ie,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);

    logic [NFLAG-1:0] flags_q;

    // set has priority over clear on the same edge
    for (genvar f = 0; f < NFLAG; f++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags_q[f] <= 1'b0;
            else if (evt[f])
                flags_q[f] <= 1'b1;
            else if (clr[f])
                flags_q[f] <= 1'b0;
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            (flags_q[f] && !clr[f]) |=> flags_q[f]); // R2 R3

        AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
            evt[f] |=> flags_q[f]); // R6
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & ie);

endmodule

// File: rtl/jat_elastic_store.sv
module jat_elastic_store
    import jat_pkg::*;
#(
    parameter int unsigned DEPTH = JAT_DEFAULT_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             rd_en,
    input  logic             lim_en,
    input  logic             center_req,
    input  logic             bypass,
    input  logic             ovr_ie,
    input  logic             und_ie,
    input  logic             clr_ovr,
    input  logic             clr_und,
    output logic             rd_bit,
    output logic             rd_valid,
    output logic [CNT_W-1:0] fill,
    output logic             ovr_flag,
    output logic             und_flag,
    output logic             irq,
    output logic             near_full,
    output logic             near_empty
);

    localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(1);

    jat_op_t          op;
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] cnt;
    logic             store_bit, store_stb;
    logic [FLG_COUNT-1:0] evt_vec, clr_vec, ie_vec, flag_vec;
    logic             irq_int;

    jat_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .center_req (center_req),
        .bypass     (bypass),
        .op         (op),
        .wptr       (wptr),
        .rptr       (rptr),
        .cnt        (cnt)
    );

    jat_bit_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_go   (op.wr_go),
        .wr_bit  (wr_bit),
        .wptr    (wptr),
        .rd_go   (op.rd_go),
        .und_evt (op.und_evt),
        .rptr    (rptr),
        .out_bit (store_bit),
        .out_stb (store_stb)
    );

    always_comb begin
        evt_vec          = '0;
        clr_vec          = '0;
        ie_vec           = '0;
        evt_vec[FLG_OVR] = op.ovr_evt;
        evt_vec[FLG_UND] = op.und_evt;
        clr_vec[FLG_OVR] = clr_ovr;
        clr_vec[FLG_UND] = clr_und;
        ie_vec[FLG_OVR]  = ovr_ie;
        ie_vec[FLG_UND]  = und_ie;
    end

    jat_status #(.NFLAG(FLG_COUNT)) u_status (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt_vec),
        .clr   (clr_vec),
        .ie    (ie_vec),
        .flags (flag_vec),
        .irq   (irq_int)
    );

    always_comb begin
        rd_bit     = bypass ? wr_bit : store_bit;
        rd_valid   = bypass ? wr_en  : store_stb;
        fill       = cnt;
        ovr_flag   = flag_vec[FLG_OVR];
        und_flag   = flag_vec[FLG_UND];
        irq        = irq_int;
        near_full  = lim_en && (cnt >= LIM_HI);
        near_empty = lim_en && (cnt <= LIM_LO);
    end

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!(ovr_flag && ovr_ie) && !(und_flag && und_ie)) |-> !irq); // R5

    AST_LIMIT_OFF: assert property (@(posedge clk) disable iff (rst)
        !lim_en |-> (!near_full && !near_empty)); // R7

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
        bypass |-> (rd_bit == wr_bit && rd_valid == wr_en)); // R9

endmodule

// File: tb/jat_elastic_store_tb.sv
module jat_elastic_store_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int D          = 48;
    localparam int HALF       = D / 2;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst, wr_en, wr_bit, rd_en, lim_en, center_req, bypass;
    logic ovr_ie, und_ie, clr_ovr, clr_und;
    logic rd_bit, rd_valid, ovr_flag, und_flag, irq, near_full, near_empty;
    logic [5:0] fill;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    jat_elastic_store dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bit(wr_bit), .rd_en(rd_en),
        .lim_en(lim_en), .center_req(center_req), .bypass(bypass),
        .ovr_ie(ovr_ie), .und_ie(und_ie), .clr_ovr(clr_ovr), .clr_und(clr_und),
        .rd_bit(rd_bit), .rd_valid(rd_valid), .fill(fill), .ovr_flag(ovr_flag),
        .und_flag(und_flag), .irq(irq), .near_full(near_full), .near_empty(near_empty)
    );

    // ---------------- behavioural reference ----------------
    bit m_mem [D];
    int wcnt, rcnt;
    bit m_out, m_vld, m_ovr, m_und;

    function automatic int idx(int v);
        return ((v % D) + D) % D;
    endfunction

    always @(posedge clk) begin
        bit ov, un;
        int occ;
        ov = 0; un = 0;
        occ = wcnt - rcnt;
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            wcnt = 0; rcnt = 0;
            m_out = 0; m_vld = 0; m_ovr = 0; m_und = 0;
        end else begin
            m_vld = rd_en && !bypass && !center_req;
            if (!bypass) begin
                if (center_req) begin
                    rcnt = wcnt - HALF;
                end else begin
                    if (rd_en && occ > 0) begin
                        m_out = m_mem[idx(rcnt)];
                        rcnt++;
                    end
                    if (wr_en && occ < D) begin
                        m_mem[idx(wcnt)] = wr_bit;
                        wcnt++;
                    end
                    ov = wr_en && occ == D;
                    un = rd_en && occ == 0;
                end
            end
            m_ovr = ov || (m_ovr && !clr_ovr);
            m_und = un || (m_und && !clr_und);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    // per-cycle comparison, after the edge and before inputs move
    always @(posedge clk) begin
        int occ;
        #(CLK_PERIOD / 8);
        occ = wcnt - rcnt;
        chk(int'(fill) == occ, "R1 fill", int'(fill), occ);
        chk(rd_bit == (bypass ? wr_bit : m_out), "R1/R3/R9 rd_bit", rd_bit,
            bypass ? wr_bit : m_out);
        chk(rd_valid == (bypass ? wr_en : m_vld), "R11 rd_valid", rd_valid,
            bypass ? wr_en : m_vld);
        chk(ovr_flag == m_ovr, "R2 ovr_flag", ovr_flag, m_ovr);
        chk(und_flag == m_und, "R3 und_flag", und_flag, m_und);
        chk(irq == ((m_ovr && ovr_ie) || (m_und && und_ie)), "R5 irq", irq,
            (m_ovr && ovr_ie) || (m_und && und_ie));
        chk(near_full == (lim_en && occ >= D - 1), "R7 near_full", near_full,
            lim_en && occ >= D - 1);
        chk(near_empty == (lim_en && occ <= 1), "R7 near_empty", near_empty,
            lim_en && occ <= 1);
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD / 4);
    endtask

    function automatic bit pat(int i);
        return ((i % 3) == 0) ^ ((i % 5) == 1);
    endfunction

    task automatic run_all();
        rst = 1;
        tick();
        chk(fill == 0 && !ovr_flag && !und_flag && !rd_bit && !irq,
            "R10 reset state", int'(fill), 0);
        tick();
        rst = 0;
        lim_en = 1;

        // fill to the top
        for (int i = 0; i < D; i++) begin
            wr_en = 1; wr_bit = pat(i);
            tick();
        end
        wr_en = 0;
        chk(fill == 6'(D), "R1 full count", int'(fill), D);
        chk(near_full == 1, "R7 near_full at 48", near_full, 1);

        // overflow: two extra writes dropped
        wr_en = 1; wr_bit = 1;
        tick(); tick();
        wr_en = 0;
        chk(ovr_flag == 1, "R2 overflow flag", ovr_flag, 1);
        chk(fill == 6'(D), "R2 fill stays 48", int'(fill), D);
        chk(irq == 0, "R5 irq masked", irq, 0);
        ovr_ie = 1;
        #1;
        chk(irq == 1, "R5 irq enabled", irq, 1);

        // drain and compare order
        rd_en = 1;
        for (int i = 0; i < D; i++) begin
            tick();
            chk(rd_bit == pat(i), "R1 order", rd_bit, pat(i));
        end
        chk(fill == 0 && near_empty == 1, "R7 empty limit", int'(fill), 0);

        // underrun: last bit repeated
        tick(); tick();
        rd_en = 0;
        chk(rd_bit == pat(D - 1), "R3 repeat last bit", rd_bit, pat(D - 1));
        chk(und_flag == 1, "R3 underrun flag", und_flag, 1);
        chk(rd_valid == 1, "R11 strobe on underrun", rd_valid, 1);

        // clear and set-wins
        clr_ovr = 1; tick(); clr_ovr = 0;
        chk(ovr_flag == 0, "R6 clear overflow", ovr_flag, 0);
        chk(und_flag == 1, "R6 underrun kept", und_flag, 1);
        rd_en = 1; clr_und = 1; tick(); rd_en = 0; clr_und = 0;
        chk(und_flag == 1, "R6 set beats clear", und_flag, 1);
        clr_und = 1; tick(); clr_und = 0;
        chk(und_flag == 0, "R6 clear underrun", und_flag, 0);

        // paired strobes in mid range
        for (int i = 0; i < 10; i++) begin
            wr_en = 1; wr_bit = pat(i + 7); tick();
        end
        rd_en = 1;
        for (int i = 0; i < 20; i++) begin
            wr_bit = pat(i); tick();
        end
        wr_en = 0; rd_en = 0;
        chk(fill == 10, "R4 paired steady", int'(fill), 10);

        // centering with conflicting strobes
        wr_en = 1; rd_en = 1; center_req = 1; tick();
        wr_en = 0; rd_en = 0; center_req = 0;
        chk(fill == 6'(HALF), "R8 center half", int'(fill), HALF);
        chk(ovr_flag == 0 && und_flag == 0, "R8 no flags", ovr_flag, 0);

        // bypass
        bypass = 1; center_req = 1; rd_en = 1;
        for (int i = 0; i < 10; i++) begin
            wr_en = (i % 3) != 2; wr_bit = pat(i);
            tick();
            chk(rd_bit == wr_bit && rd_valid == wr_en, "R9 pass through",
                rd_bit, wr_bit);
        end
        bypass = 0; center_req = 0; rd_en = 0; wr_en = 0;
        tick();
        chk(fill == 6'(HALF), "R9 fill kept", int'(fill), HALF);

        // random mix
        for (int i = 0; i < 6000; i++) begin
            wr_en      = ($urandom % 2) == 0;
            rd_en      = ($urandom % 2) == 0;
            wr_bit     = $urandom % 2;
            center_req = ($urandom % 64) == 0;
            bypass     = ($urandom % 32) == 0;
            clr_ovr    = ($urandom % 16) == 0;
            clr_und    = ($urandom % 16) == 0;
            if (($urandom % 8) == 0) begin
                ovr_ie = $urandom % 2; und_ie = $urandom % 2; lim_en = $urandom % 2;
            end
            if ((i / 500) % 2 == 0 && wr_en == 0) wr_en = ($urandom % 3) == 0;
            tick();
        end
        wr_en = 0; rd_en = 0; center_req = 0; bypass = 0;
        tick();
    endtask

    initial begin
        rst = 1; wr_en = 0; wr_bit = 0; rd_en = 0; lim_en = 0; center_req = 0;
        bypass = 0; ovr_ie = 0; und_ie = 0; clr_ovr = 0; clr_und = 0;
        fork
            run_all();
            begin
                wait (cyc >= WATCHDOG);
                n_checks++;
                n_err++;
                $display("FAIL watchdog expired at cycle %0d: actual=%0d expected=%0d",
                         cyc, cyc, WATCHDOG);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule